// File: doc/BRIEF.md
# Clamp Window Generator

The block produces, once per video line, the timing strobes that tell an input conditioning stage when the incoming signal sits at its reference level. In internal mode it counts pixel clocks from the trailing edge of the horizontal sync input. It raises a window a programmed number of clocks later and holds it for a programmed number of clocks. The window can be shared between an analog clamp and a digital black-level loop. They can work over the whole window together, or the clamp can take the first part and the loop the remainder.

Around vertical sync the window is suppressed for a programmed number of lines before and after the line in which vertical sync begins. The lines before are located using the length of the previous field. An external clamp pin can replace the internal timing. It has a selectable active level and is sampled on the pixel clock. Both strobes leave the block from registers.

Top module: `clamp_window_gen`

## Requirements
- R1: In internal mode (`use_pin`=0), if `hsync_in` is first seen low at clock edge E after being high, `clamp_on` is high from the output of edge E+`place`+1 for `duration` consecutive cycles, as long as no new trailing edge arrives first.
- R2: A `duration` of 0 produces no strobe on either output.
- R3: With `split`=0, `loop_on` is high in exactly the same cycles as `clamp_on`.
- R4: With `split`=m>0 and m<`duration`, `clamp_on` covers the first m cycles of the window and `loop_on` the remaining `duration`-m cycles, with no overlap.
- R5: While `loop_off` or `loop_hold` is 1, `loop_on` stays low and `clamp_on` is unaffected.
- R6: A trailing edge of `hsync_in` that arrives while a window is still counting restarts the count. The current window then ends after the cycle in which the new edge is seen.
- R7: Lines are counted on rising edges of `hsync_in`. The line in which `vsync_in` rises is line 0 of a field. Lines 0 to `post_coast`-1 of every field open no window.
- R8: Once two rising edges of `vsync_in` have been seen, the field length N is the line count of the previous field. Lines N-`pre_coast` to N-1 then open no window. A `pre_coast` of 0 suppresses nothing.
- R9: In pin mode (`use_pin`=1) the pin is active when `clamp_pin` differs from `pin_active_low`. The level seen at edge E appears on `clamp_on` after edge E. `loop_on` follows `clamp_on`, is gated as in R5, and ignores `split`.
- R10: While `rst_n` is low both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| clamp_pin | input | 1 | External clamp timing pin |
| use_pin | input | 1 | 1 selects the external pin, 0 the internal generator |
| pin_active_low | input | 1 | 1 makes the external pin active low |
| place | input | CNT_W | Delay from hsync trailing edge to window start, in clocks |
| duration | input | CNT_W | Window length in clocks |
| split | input | CNT_W | Clamp share of the window; 0 shares the whole window |
| pre_coast | input | CNT_W | Lines suppressed before the vsync line |
| post_coast | input | CNT_W | Lines suppressed from the vsync line onward |
| loop_off | input | 1 | Loop disabled |
| loop_hold | input | 1 | Loop state held |
| clamp_on | output | 1 | Analog clamp strobe |
| loop_on | output | 1 | Black-level loop strobe |

## Verification
The internal generator is driven with lines long enough for full windows. It is also driven with lines shorter than place plus duration, which separates a clean restart from a window that runs on through the next edge. The same line train is replayed with the split value zero and nonzero, and with each loop gate set. This shows whether the two strobes divide the window or merely coincide. A multi-field sequence with a two-line vertical pulse shows whether suppression is anchored at the vsync line and whether the pre-vsync lines come from the previous field's count. External-pin pulses at both polarities check that the pin takes over and that the latency is a single register.

// File: rtl/clamp_window_gen.sv
module clamp_window_gen #(
  parameter int CNT_W  = 8,
  parameter int LINE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             clamp_pin,
  input  logic             use_pin,
  input  logic             pin_active_low,
  input  logic [CNT_W-1:0] place,
  input  logic [CNT_W-1:0] duration,
  input  logic [CNT_W-1:0] split,
  input  logic [CNT_W-1:0] pre_coast,
  input  logic [CNT_W-1:0] post_coast,
  input  logic             loop_off,
  input  logic             loop_hold,
  output logic             clamp_on,
  output logic             loop_on
);
  localparam int POS_W = CNT_W + 1;
  localparam int LX_W  = LINE_W + 1;
  typedef logic [POS_W-1:0] pos_t;
  typedef logic [LX_W-1:0]  lx_t;

  logic hs_q, vs_q;
  logic hs_fall, hs_rise, vs_rise;
  assign hs_fall = hs_q & ~hsync_in;
  assign hs_rise = ~hs_q & hsync_in;
  assign vs_rise = ~vs_q & vsync_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync_in;
      vs_q <= vsync_in;
    end

  logic [LINE_W-1:0] line_cnt;
  lx_t  field_len;
  logic have_len, seen_vs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_cnt  <= '1;
      field_len <= '0;
      have_len  <= 1'b0;
      seen_vs   <= 1'b0;
    end else if (vs_rise) begin
      line_cnt  <= '0;
      field_len <= lx_t'(line_cnt) + lx_t'(1);
      have_len  <= seen_vs;
      seen_vs   <= 1'b1;
    end else if (hs_rise && line_cnt != '1) begin
      line_cnt <= line_cnt + 1'b1;
    end

  logic in_post, in_pre, coast;
  assign in_post = lx_t'(line_cnt) < lx_t'(post_coast);
  assign in_pre  = have_len && (pre_coast != '0) &&
                   (lx_t'(line_cnt) + lx_t'(pre_coast) >= field_len);
  assign coast   = in_post | in_pre;

  logic run;
  pos_t pos;
  pos_t win_end, offs;
  assign win_end = pos_t'(place) + pos_t'(duration);
  assign offs    = pos - pos_t'(place);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0;
      pos <= '0;
    end else if (hs_fall) begin
      run <= ~coast;
      pos <= '0;
    end else if (run) begin
      if (pos >= win_end) run <= 1'b0;
      else                pos <= pos + 1'b1;
    end

  logic in_win, first_part, int_clamp, int_loop, pin_act, src_clamp, src_loop;
  assign in_win     = run && (pos >= pos_t'(place)) && (pos < win_end);
  assign first_part = offs < pos_t'(split);
  assign int_clamp  = in_win && ((split == '0) || first_part);
  assign int_loop   = in_win && ((split == '0) || !first_part);
  assign pin_act    = (clamp_pin ^ pin_active_low) & ~coast;
  assign src_clamp  = use_pin ? pin_act : int_clamp;
  assign src_loop   = (use_pin ? pin_act : int_loop) & ~(loop_off | loop_hold);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clamp_on <= 1'b0;
      loop_on  <= 1'b0;
    end else begin
      clamp_on <= src_clamp;
      loop_on  <= src_loop;
    end
endmodule

module clamp_window_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             use_pin,
  input logic             clamp_pin,
  input logic             pin_active_low,
  input logic [CNT_W-1:0] split,
  input logic [CNT_W-1:0] pre_coast,
  input logic [CNT_W-1:0] post_coast,
  input logic             loop_off,
  input logic             loop_hold,
  input logic             clamp_on,
  input logic             loop_on
);
  // R5
  loop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> !$past(loop_off || loop_hold));

  // R4
  phase_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_on && loop_on) |-> ($past(split) == '0 || $past(use_pin)));

  // R9
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(use_pin && pre_coast == '0 && post_coast == '0)
      |-> (clamp_on == $past(clamp_pin ^ pin_active_low)));

  // R3
  loop_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!use_pin && split == '0 && !loop_off && !loop_hold)
      |-> (loop_on == clamp_on));
endmodule

bind clamp_window_gen clamp_window_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/clamp_window_gen_test.sv
module clamp_window_gen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, clamp_pin = 1'b0;
  logic use_pin = 1'b0, pin_active_low = 1'b0;
  logic [7:0] place = 8'd5, duration = 8'd12, split = 8'd0;
  logic [7:0] pre_coast = 8'd0, post_coast = 8'd0;
  logic loop_off = 1'b0, loop_hold = 1'b0;
  logic clamp_on, loop_on;

  clamp_window_gen uut (.*);

  always #2 clk = ~clk;

  typedef struct { int s; int n; string r; } pulse_t;
  pulse_t qc[$], ql[$];
  int checks = 0, errors = 0, t = 0;
  bit started = 0, finished = 0;
  int b_line = 2047, b_len = 0;
  bit b_have = 0, b_seen = 0, b_pvs = 0;

  task automatic tick();
    @(posedge clk); #1; t++;
  endtask

  task automatic cfg(int pl, int du, int sp, bit off, bit hold, int pre, int post, string r);
    tick();
    place = 8'(pl); duration = 8'(du); split = 8'(sp);
    loop_off = off; loop_hold = hold; pre_coast = 8'(pre); post_coast = 8'(post);
    repeat (8) tick();
  endtask

  task automatic push_line(int k, int L, bit last, bit co, string r);
    int e, s, m;
    m = int'(split);
    if (co || duration == 0) return;
    e = int'(duration);
    if (!last && (L - int'(place)) < e) e = L - int'(place);
    if (e <= 0) return;
    s = k + int'(place) + 2;
    qc.push_back('{s, (m == 0 || m > e) ? e : m, r});
    if (!loop_off && !loop_hold) begin
      if (m == 0) ql.push_back('{s, e, r});
      else if (e > m) ql.push_back('{s + m, e - m, r});
    end
  endtask

  task automatic line(int L, bit vs, bit last, string r);
    bit co;
    if (vs && !b_pvs) begin
      if (b_seen) begin b_len = b_line + 1; b_have = 1; end
      b_seen = 1; b_line = 0;
    end else if (b_line != 2047) b_line++;
    b_pvs = vs;
    co = (b_line < int'(post_coast)) ||
         (b_have && pre_coast != 0 && b_line + int'(pre_coast) >= b_len);
    tick(); hsync_in = 1'b1; vsync_in = vs;
    repeat (3) tick();
    tick(); hsync_in = 1'b0;
    push_line(t, L, last, co, r);
    repeat (L - 5) tick();
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic pin_pulse(int len, string r);
    tick(); clamp_pin = ~pin_active_low;
    qc.push_back('{t + 1, len, r});
    if (!loop_off && !loop_hold) ql.push_back('{t + 1, len, r});
    repeat (len - 1) tick();
    tick(); clamp_pin = pin_active_low;
  endtask

  task automatic compare(string nm, int s, int n, ref pulse_t q[$]);
    pulse_t x;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL unexpected %s pulse: start %0d len %0d expected none", nm, s, n);
    end else begin
      x = q.pop_front();
      if (x.s != s || x.n != n) begin
        errors++;
        $display("FAIL %s %s pulse: start %0d len %0d expected start %0d len %0d",
                 x.r, nm, s, n, x.s, x.n);
      end
    end
  endtask

  bit pc = 0, pl = 0;
  int cs = 0, ls = 0;
  always @(negedge clk) if (started && !finished) begin
    if (clamp_on && !pc) cs = t;
    if (!clamp_on && pc) compare("clamp", cs, t - cs, qc);
    if (loop_on && !pl) ls = t;
    if (!loop_on && pl) compare("loop", ls, t - ls, ql);
    pc = clamp_on; pl = loop_on;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: running %0d cycles expected completion", wd);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (clamp_on !== 1'b0 || loop_on !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset outputs: %b%b expected 00", clamp_on, loop_on);
    end
    #1 rst_n = 1'b1;
    started = 1;
    idle(5);

    // R1 R3: full windows, loop shares the whole window
    cfg(5, 12, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 4; i++) line(40, 0, i == 3, "R1_R3");
    idle(40);
    // R4: clamp first 4 clocks, loop the rest
    cfg(5, 12, 4, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) line(40, 0, i == 3, "R4");
    idle(40);
    // R5: loop gates
    cfg(6, 10, 0, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) line(40, 0, i == 2, "R5_off");
    idle(40);
    cfg(6, 10, 3, 0, 1, 0, 0, "R5");
    for (int i = 0; i < 3; i++) line(40, 0, i == 2, "R5_hold");
    idle(40);
    // R6: windows longer than a line restart
    cfg(10, 30, 0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) line(20, 0, i == 3, "R6");
    idle(50);
    cfg(10, 30, 6, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) line(20, 0, i == 2, "R6_split");
    idle(50);
    // R2: zero duration
    cfg(4, 0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) line(40, 0, i == 2, "R2");
    idle(40);
    // R7 R8: coast around vertical sync, 6-line fields
    cfg(3, 6, 0, 0, 0, 2, 1, "R7");
    line(24, 0, 0, "R8_prefield");
    line(24, 0, 0, "R8_prefield");
    for (int f = 0; f < 4; f++) begin
      line(24, 1, 0, "R7");
      line(24, 1, 0, "R7");
      for (int i = 0; i < 4; i++) line(24, 0, f == 3 && i == 3, "R8");
    end
    idle(40);
    // R9: external pin, both polarities
    cfg(5, 12, 4, 0, 0, 0, 0, "R9");
    tick(); clamp_pin = 1'b0; pin_active_low = 1'b0; use_pin = 1'b1;
    idle(6);
    pin_pulse(7, "R9_high");
    idle(10);
    pin_pulse(3, "R9_high");
    idle(10);
    tick(); clamp_pin = 1'b1; pin_active_low = 1'b1; loop_off = 1'b1;
    idle(6);
    pin_pulse(5, "R9_low");
    idle(20);

    finished = 1;
    while (qc.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s clamp pulse missing: none expected start %0d len %0d", qc[0].r, qc[0].s, qc[0].n);
      void'(qc.pop_front());
    end
    while (ql.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s loop pulse missing: none expected start %0d len %0d", ql[0].r, ql[0].s, ql[0].n);
      void'(ql.pop_front());
    end
    summary();
  end
endmodule